// File: doc/BRIEF.md
# Watchdog timer with two-key feed guard

This block is a watchdog timer that sits on a small peripheral register bus. Once software turns it on, a down-counter runs from a programmable reload value. If the counter reaches zero, the block raises a reset request. Software prevents that by feeding the watchdog, which means writing an arm key and then a commit key to the feed register. A correct feed reloads the counter.

While a feed is half done, the block watches the whole bus. A separate input flags accesses that target other peripherals. Any access other than the commit write is treated as a broken feed and raises the reset request at once, without waiting for the counter.

The reset request stays high for a fixed number of cycles. A sticky cause flag records that the watchdog produced it. The counter is wide enough for timeouts of several seconds at normal bus clock rates.

Top module: `wdt_keyed`

## Requirements
- R1: After reset, `wdt_reset` is low. The control register (word 0) reads 0. The timeout register (word 1) and the count register (word 3) both read the parameter `TIMEOUT_RST`.
- R2: Writing 1 to control bit 0 enables the watchdog and loads the counter from the timeout register. Writing 0 to that bit never clears it; only `rst_n` clears it.
- R3: While enabled and no reset pulse is active, the count drops by one each cycle. In the cycle where it reads 0, a reset request is started, and `wdt_reset` goes high on the next cycle.
- R4: A feed is a write whose low byte is 0xAA to word 2, followed later by a write whose low byte is 0x55 to word 2. Idle bus cycles between the two writes are allowed. A complete feed reloads the counter from the timeout register on the edge that takes the 0x55 write, and returns the tracker to idle.
- R5: While enabled, after the 0xAA write, any other access breaks the feed. This covers any read or write of this block's registers (including a wrong feed value) and any cycle with `other_access` high, even one that coincides with the 0x55 write. `wdt_reset` then rises on the very next cycle, whatever the count.
- R6: While the tracker is idle, a write to word 2 whose low byte is not 0xAA has no effect: no reset, and the count keeps running.
- R7: Reads of the count register return the current count. Reads and `other_access` cycles do not disturb an idle tracker, so a following 0xAA/0x55 pair still feeds.
- R8: Each reset request holds `wdt_reset` high for exactly `RST_CYCLES` cycles and sets control bit 1 (cause flag). Writing 1 to control bit 1 clears the flag.
- R9: While disabled, neither a broken feed nor the count produces a reset request, and the count holds.
- R10: During the reset pulse the count holds at the timeout value loaded when the request fired. Feed writes are ignored. Counting resumes from that value after the pulse ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access to this block in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word index: 0 control, 1 timeout, 2 feed, 3 count |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for the word at `bus_addr` |
| other_access | input | 1 | Bus access to any other peripheral in this cycle |
| wdt_reset | output | 1 | Reset request pulse |

## Verification
The feed is exercised in several forms:
- clean pairs with and without idle gaps;
- stray non-key writes while idle;
- an arm key followed by each kind of intruder: a foreign access, a register read, a wrong value, a repeated arm key, and a commit key that coincides with a foreign access.

These patterns separate a tracker that inspects only feed writes from one that watches every access. Letting the count run out, both with and without the block enabled, separates the expiry path from the fault path. The pulse width and the count hold during the pulse are measured on every request.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;
  typedef enum logic [1:0] {
    REG_CTRL    = 2'd0,
    REG_TIMEOUT = 2'd1,
    REG_FEED    = 2'd2,
    REG_COUNT   = 2'd3
  } wdt_reg_e;

  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_ARMED = 1'b1
  } seq_state_e;

  localparam logic [7:0] KEY_ARM    = 8'hAA;
  localparam logic [7:0] KEY_COMMIT = 8'h55;

  function automatic logic key_match(input logic [7:0] b, input logic [7:0] key);
    return b == key;
  endfunction
endpackage

// File: rtl/wdt_feed_seq.sv
module wdt_feed_seq
  import wdt_keyed_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold,
  input  logic       bus_sel,
  input  logic       feed_wr,
  input  logic [7:0] key_byte,
  input  logic       other_access,
  output logic       feed_ok,
  output logic       seq_fault,
  output logic       armed
);
  seq_state_e state_q, state_d;
  logic arm_hit, commit_hit;

  assign arm_hit    = feed_wr && key_match(key_byte, KEY_ARM);
  assign commit_hit = feed_wr && key_match(key_byte, KEY_COMMIT) && !other_access;

  always_comb begin
    state_d   = state_q;
    feed_ok   = 1'b0;
    seq_fault = 1'b0;
    if (hold) begin
      state_d = SEQ_IDLE;
    end else if (state_q == SEQ_ARMED) begin
      if (commit_hit) begin
        feed_ok = 1'b1;
        state_d = SEQ_IDLE;
      end else if (bus_sel || other_access) begin
        seq_fault = 1'b1;
        state_d   = SEQ_IDLE;
      end
    end else if (arm_hit) begin
      state_d = SEQ_ARMED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  assign armed = (state_q == SEQ_ARMED);

  // R5: an intruding access always resolves the armed state
  p_fault_idles_r5: assert property (@(posedge clk) disable iff (!rst_n)
    seq_fault |=> !armed);
  // R6: while idle, nothing but the arm key can arm the tracker
  p_idle_needs_key_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !(feed_wr && key_byte == 8'hAA)) |=> !armed);
  // R7: a read while idle leaves the tracker idle
  p_read_keeps_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && bus_sel && !feed_wr && !hold) |=> !armed);
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
  parameter int          CNT_W = 32,
  parameter logic [31:0] INIT  = 32'h0FFF_FFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             at_zero
);
  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v);
    return v - {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= INIT[CNT_W-1:0];
    else if (load) cnt_q <= load_val;
    else if (run)  cnt_q <= step_down(cnt_q);
  end

  assign count   = cnt_q;
  assign at_zero = (cnt_q == '0);

  // R4: a reload takes the value offered on the loading edge
  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == $past(load_val));
  // R10, R9: without run or load the count holds
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse #(
  parameter int RST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic active
);
  localparam int RC_W = $clog2(RST_CYCLES + 1);
  localparam logic [RC_W-1:0] RC_LOAD = RC_W'(RST_CYCLES);

  logic [RC_W-1:0] rc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              rc_q <= '0;
    else if (fire)           rc_q <= RC_LOAD;
    else if (rc_q != '0)     rc_q <= rc_q - 1'b1;
  end

  assign active = (rc_q != '0);

  // R8: a request always shows up on the output next cycle
  p_fire_shows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> active);
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_keyed_pkg::*;
#(
  parameter int          CNT_W       = 32,
  parameter int          RST_CYCLES  = 16,
  parameter logic [31:0] TIMEOUT_RST = 32'h0FFF_FFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             other_access,
  output logic             wdt_reset
);
  logic             en_q, flag_q;
  logic [CNT_W-1:0] timeout_q;
  logic             ctrl_wr, tmo_wr, feed_wr;
  logic             en_rise, flag_clr;
  logic             feed_ok, seq_fault, armed;
  logic             pulse_active, fire, cnt_load, cnt_run, at_zero;
  logic [CNT_W-1:0] count;

  assign ctrl_wr  = bus_sel && bus_wr && (bus_addr == REG_CTRL);
  assign tmo_wr   = bus_sel && bus_wr && (bus_addr == REG_TIMEOUT);
  assign feed_wr  = bus_sel && bus_wr && (bus_addr == REG_FEED);
  assign en_rise  = ctrl_wr && bus_wdata[0] && !en_q;
  assign flag_clr = ctrl_wr && bus_wdata[1];

  wdt_feed_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .hold         (pulse_active),
    .bus_sel      (bus_sel),
    .feed_wr      (feed_wr),
    .key_byte     (bus_wdata[7:0]),
    .other_access (other_access),
    .feed_ok      (feed_ok),
    .seq_fault    (seq_fault),
    .armed        (armed)
  );

  assign fire     = en_q && !pulse_active && (seq_fault || at_zero);
  assign cnt_run  = en_q && !pulse_active;
  assign cnt_load = fire || feed_ok || en_rise;

  wdt_down_counter #(.CNT_W(CNT_W), .INIT(TIMEOUT_RST)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (cnt_run),
    .load     (cnt_load),
    .load_val (timeout_q),
    .count    (count),
    .at_zero  (at_zero)
  );

  wdt_rst_pulse #(.RST_CYCLES(RST_CYCLES)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (fire),
    .active (pulse_active)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      flag_q    <= 1'b0;
      timeout_q <= TIMEOUT_RST[CNT_W-1:0];
    end else begin
      if (ctrl_wr && bus_wdata[0]) en_q <= 1'b1;
      if (fire)          flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
      if (tmo_wr) timeout_q <= bus_wdata;
    end
  end

  always_comb begin
    unique case (bus_addr)
      REG_CTRL:    bus_rdata = {{(CNT_W-2){1'b0}}, flag_q, en_q};
      REG_TIMEOUT: bus_rdata = timeout_q;
      REG_FEED:    bus_rdata = '0;
      default:     bus_rdata = count;
    endcase
  end

  assign wdt_reset = pulse_active;

  // R2: enable is sticky
  p_en_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q);
  // R5: a broken feed while enabled raises the output next cycle
  p_fault_fires_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_fault && en_q && !wdt_reset) |=> wdt_reset);
  // R3: reaching zero while running raises the output next cycle
  p_zero_fires_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (at_zero && en_q && !wdt_reset) |=> wdt_reset);
  // R8: the cause flag is set whenever the output rises
  p_flag_on_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_reset) |-> flag_q);
  // R9: no request while disabled
  p_quiet_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !wdt_reset);
endmodule

// File: tb/wdt_keyed_tb.sv
module wdt_keyed_tb;
  localparam int          CNT_W = 32;
  localparam int          RSTC  = 16;
  localparam logic [31:0] TINIT = 32'h0FFF_FFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic b_sel = 1'b0, b_wr = 1'b0, oth = 1'b0;
  logic [1:0] b_addr = 2'd0;
  logic [31:0] b_wdata = '0;
  logic [31:0] b_rdata;
  logic wrst;

  int checks = 0, errors = 0, cyc = 0;

  always #2 clk = ~clk;

  wdt_keyed #(.CNT_W(CNT_W), .RST_CYCLES(RSTC), .TIMEOUT_RST(TINIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(b_sel), .bus_wr(b_wr), .bus_addr(b_addr),
    .bus_wdata(b_wdata), .bus_rdata(b_rdata), .other_access(oth), .wdt_reset(wrst));

  // behavioural reference
  logic [31:0] m_cnt, m_to;
  bit m_en, m_flag, m_armed;
  int m_rc;
  bit mp, mfw, mfault, mfok, mfire, mrise;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = TINIT; m_to = TINIT; m_en = 0; m_flag = 0; m_armed = 0; m_rc = 0;
    end else begin
      mp = (m_rc != 0);
      mfw = b_sel && b_wr && b_addr == 2'd2;
      mfault = 0; mfok = 0;
      if (mp) m_armed = 0;
      else if (m_armed) begin
        if (mfw && b_wdata[7:0] == 8'h55 && !oth) mfok = 1;
        else if (b_sel || oth) mfault = 1;
        if (mfok || mfault) m_armed = 0;
      end else if (mfw && b_wdata[7:0] == 8'hAA) m_armed = 1;
      mfire = m_en && !mp && (mfault || m_cnt == 0);
      mrise = b_sel && b_wr && b_addr == 2'd0 && b_wdata[0] && !m_en;
      if (mfire || mfok || mrise) m_cnt = m_to;
      else if (m_en && !mp) m_cnt = m_cnt - 1;
      if (mfire) m_rc = RSTC; else if (mp) m_rc = m_rc - 1;
      if (mfire) m_flag = 1;
      else if (b_sel && b_wr && b_addr == 2'd0 && b_wdata[1]) m_flag = 0;
      if (b_sel && b_wr && b_addr == 2'd0 && b_wdata[0]) m_en = 1;
      if (b_sel && b_wr && b_addr == 2'd1) m_to = b_wdata;
    end
  end

  function automatic logic [31:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return {30'd0, m_flag, m_en};
      2'd1: return m_to;
      2'd2: return 32'd0;
      default: return m_cnt;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // per-cycle compare of the reset output and pulse width
  int hi_len = 0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R3/R5/R8 wdt_reset vs model", {31'd0, wrst}, {31'd0, m_rc != 0});
      if (wrst) hi_len++;
      else if (hi_len != 0) begin
        chk("R8 pulse width", hi_len, RSTC);
        hi_len = 0;
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); b_sel = 0; oth = 0; b_wr = 0;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic o);
    @(negedge clk); b_sel = 1; b_wr = 1; b_addr = a; b_wdata = d; oth = o;
  endtask

  task automatic rd(input string tag, input logic [1:0] a);
    @(negedge clk); b_sel = 1; b_wr = 0; b_addr = a; oth = 0;
    #1 chk(tag, b_rdata, m_read(a));
  endtask

  task automatic foreign();
    @(negedge clk); b_sel = 0; b_wr = 0; oth = 1;
  endtask

  task automatic clear_flag();
    idle(RSTC + 2);
    wr(2'd0, 32'h2, 0);
    rd("R8 flag cleared", 2'd0);
    chk("R8 flag cleared value", b_rdata, 32'h1);
  endtask

  initial begin
    fork
      begin
        #400000;
        errors++;
        $display("FAIL watchdog: run hung");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none

    idle(3);
    rst_n = 1;
    // R1 reset state
    rd("R1 count after reset", 2'd3);
    chk("R1 count value", b_rdata, TINIT);
    rd("R1 ctrl after reset", 2'd0);
    chk("R1 ctrl value", b_rdata, 32'h0);
    rd("R1 timeout after reset", 2'd1);

    // R9 disabled: broken feed and short timeout do nothing
    wr(2'd1, 32'd5, 0);
    wr(2'd2, 32'hAA, 0);
    foreign();
    idle(20);
    rd("R9 count holds while disabled", 2'd3);
    chk("R9 count value", b_rdata, TINIT);

    // R2 enable loads counter
    wr(2'd1, 32'd200, 0);
    wr(2'd0, 32'h1, 0);
    rd("R2 count after enable", 2'd3);
    chk("R2 loaded value", b_rdata, 32'd200);
    rd("R3 count steps", 2'd3);
    chk("R3 decremented value", b_rdata, 32'd199);
    wr(2'd0, 32'h0, 0);
    rd("R2 enable sticky", 2'd0);
    chk("R2 enable bit", b_rdata, 32'h1);

    // R4 clean feeds, with and without gap
    idle(30);
    wr(2'd2, 32'hAA, 0); wr(2'd2, 32'h55, 0);
    rd("R4 reload after feed", 2'd3);
    chk("R4 reload value", b_rdata, 32'd200);
    idle(20);
    wr(2'd2, 32'hAA, 0); idle(5); wr(2'd2, 32'h1234_5655, 0);
    rd("R4 reload after gapped feed", 2'd3);

    // R6 stray writes while idle
    idle(10);
    wr(2'd2, 32'h55, 0); wr(2'd2, 32'h12, 0);
    idle(2);
    rd("R6 count keeps running", 2'd3);

    // R7 reads and foreign accesses while idle, then feed
    rd("R7 read count idle", 2'd3); foreign(); rd("R7 read ctrl idle", 2'd0);
    wr(2'd2, 32'hAA, 0); wr(2'd2, 32'h55, 0);
    rd("R7 feed still works", 2'd3);
    chk("R7 reload value", b_rdata, 32'd200);

    // R5 intruders
    wr(2'd2, 32'hAA, 0); foreign();
    idle(1); rd("R5 foreign intruder flag", 2'd0);
    chk("R5 flag after foreign", b_rdata, 32'h3);
    clear_flag();
    wr(2'd2, 32'hAA, 0); rd("R5 read intruder", 2'd3);
    clear_flag();
    wr(2'd2, 32'hAA, 0); wr(2'd2, 32'h12, 0);
    clear_flag();
    wr(2'd2, 32'hAA, 0); wr(2'd2, 32'hAA, 0);
    clear_flag();
    wr(2'd2, 32'hAA, 0); wr(2'd2, 32'h55, 1);
    // R10 hold during pulse, feed ignored
    idle(3);
    rd("R10 count held in pulse", 2'd3);
    chk("R10 held value", b_rdata, 32'd200);
    wr(2'd2, 32'hAA, 0); wr(2'd2, 32'h55, 0);
    clear_flag();

    // R3 expiry
    wr(2'd1, 32'd30, 0);
    wr(2'd2, 32'hAA, 0); wr(2'd2, 32'h55, 0);
    idle(40);
    rd("R10 count after expiry", 2'd3);
    idle(RSTC + 5);
    rd("R10 counting resumes", 2'd3);
    idle(5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule